// File: doc/BRIEF.md
# Bit-Sliced Four-Function Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit, built as a chain of identical one-bit cells. The default width is eight bits. A two-bit operation code chooses one of four operations on the two operand words: sum, two's-complement difference, bitwise OR, or bitwise AND. The block drives a result word and a single carry flag. It has no clock, no reset and no storage, so its outputs follow its inputs within the same cycle.

Every cell holds an AND gate, an OR gate, a conditional inverter on its B bit, a full adder, and output selection. The carry leaves each cell and enters the next. The low bit of the operation code does two jobs: it turns on the B inversion, and it is wired straight into the first cell's carry input. Subtraction is therefore A plus the inverted B plus one. For a difference, the carry flag reads 1 when the result is not negative (A ≥ B, unsigned). For the two logic operations the carry flag is held at 0.

Top module: `ripple_alu`

## Requirements
- R1: With op code 2'b00, {carry_out, result} equals the unsigned sum opnd_a + opnd_b, with the carry as bit WIDTH.
- R2: With op code 2'b01, result equals (opnd_a − opnd_b) modulo 2^WIDTH.
- R3: With op code 2'b01, carry_out is 1 exactly when opnd_a ≥ opnd_b as unsigned values.
- R4: With op code 2'b10, result equals opnd_a | opnd_b bit by bit.
- R5: With op code 2'b11, result equals opnd_a & opnd_b bit by bit.
- R6: Whenever op code bit 1 is set (OR or AND), carry_out is 0, whatever the operands.
- R7: The first cell's carry input equals op code bit 0. With both operands all ones, the outputs are: sum gives carry 1 and result 0xFE; difference gives carry 1 and result 0x00; OR and AND each give carry 0 and result 0xFF.
- R8: A carry produced in bit 0 travels through every cell. 0xFF + 0x01 gives result 0x00 with carry_out 1, and 0x00 − 0x01 gives 0xFF with carry_out 0.
- R9: The outputs depend only on the present inputs. A change of operands or op code shows up at the outputs before any clock edge, and no earlier input has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| func_sel | input | 2 | Operation code: 00 sum, 01 difference, 10 OR, 11 AND |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry from the top cell; 0 for logic operations |

## Verification
The bench checks every operand pair for sum and difference, and a dense grid of pairs for OR and AND. Each result is compared with an integer model. The all-ones case, the single-carry ripple from bit 0 to bit 7, and a zero minus one borrow are driven on purpose. A chain that lost a carry between cells would give a wrong upper byte in exactly those cases. A first-cell carry tied to 0 would make every difference one short. A carry flag left ungated would read 1 for OR or AND of large operands, and an inverted sign reading would fail on every equal-operand difference. Operands and op codes are also changed between clock edges, with the outputs checked before the next edge. This catches any hidden state left over from an earlier input.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

  typedef enum logic [1:0] {
    OP_SUM  = 2'b00,
    OP_DIFF = 2'b01,
    OP_OR   = 2'b10,
    OP_AND  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  // one-bit full adder, written as gate equations
  function automatic fa_out_t full_add(input logic x, input logic y, input logic c);
    fa_out_t o;
    logic    half;
    half    = x ^ y;
    o.sum   = half ^ c;
    o.carry = (x & y) | (c & half);
    return o;
  endfunction

  // logic operations live where op bit 1 is set
  function automatic logic is_logic_op(input logic [1:0] op);
    return op[1];
  endfunction

  // op bit 0 both inverts B and feeds the first carry
  function automatic logic invert_b(input logic [1:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/ripple_alu_fa.sv
module ripple_alu_fa
  import ripple_alu_pkg::*;
(
  input  logic x_in,
  input  logic y_in,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);

  fa_out_t fa_res;

  always_comb fa_res = full_add(x_in, y_in, c_in);

  assign s_out = fa_res.sum;
  assign c_out = fa_res.carry;

  // R1
  always_comb begin
    fa_count_chk: assert ({c_out, s_out} == 2'(x_in) + 2'(y_in) + 2'(c_in))
      else $error("full adder count mismatch");
  end

endmodule

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice
  import ripple_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic [1:0] op,
  input  logic       carry_in,
  output logic       z_bit,
  output logic       carry_fwd
);

  logic b_eff;
  logic and_bit;
  logic or_bit;
  logic sum_bit;
  logic add_carry;
  logic logic_sel;

  assign b_eff   = b_bit ^ invert_b(op);
  assign and_bit = a_bit & b_bit;
  assign or_bit  = a_bit | b_bit;

  ripple_alu_fa u_fa (
    .x_in  (a_bit),
    .y_in  (b_eff),
    .c_in  (carry_in),
    .s_out (sum_bit),
    .c_out (add_carry)
  );

  assign logic_sel = is_logic_op(op);

  always_comb begin
    if (logic_sel) z_bit = op[0] ? and_bit : or_bit;
    else           z_bit = sum_bit;
  end

  assign carry_fwd = logic_sel ? 1'b0 : add_carry;

  // R6
  always_comb begin
    slice_cgate_chk: assert (!(op[1] && carry_fwd))
      else $error("slice carry live during logic op");
  end

  // R4
  always_comb begin
    slice_or_chk: assert (op != OP_OR || z_bit == (a_bit | b_bit))
      else $error("slice OR wrong");
  end

  // R5
  always_comb begin
    slice_and_chk: assert (op != OP_AND || z_bit == (a_bit & b_bit))
      else $error("slice AND wrong");
  end

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carry_chain;

  // first cell's carry input is the subtract control
  assign carry_chain[0] = invert_b(func_sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    ripple_alu_slice u_slice (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .op        (func_sel),
      .carry_in  (carry_chain[i]),
      .z_bit     (result[i]),
      .carry_fwd (carry_chain[i+1])
    );
  end

  assign carry_out = carry_chain[WIDTH];

  // R1
  always_comb begin
    sum_word_chk: assert (func_sel != OP_SUM ||
                          {carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
      else $error("sum word wrong");
  end

  // R2
  always_comb begin
    diff_word_chk: assert (func_sel != OP_DIFF || result == WIDTH'(opnd_a - opnd_b))
      else $error("difference word wrong");
  end

  // R3
  always_comb begin
    diff_sign_chk: assert (func_sel != OP_DIFF || carry_out == (opnd_a >= opnd_b))
      else $error("difference sign flag wrong");
  end

  // R6
  always_comb begin
    logic_flag_chk: assert (!func_sel[1] || !carry_out)
      else $error("carry flag set during logic op");
  end

endmodule

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_drv = '0;
  logic [7:0] b_drv = '0;
  logic [1:0] op_drv = '0;
  logic [7:0] z_mon;
  logic       c_mon;

  int n_cmp = 0;
  int n_bad = 0;
  int n_cyc = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_alu #(.WIDTH(8)) dut_i (
    .opnd_a    (a_drv),
    .opnd_b    (b_drv),
    .func_sel  (op_drv),
    .result    (z_mon),
    .carry_out (c_mon)
  );

  // behavioural model: 9-bit {carry, result}
  function automatic int model(input int a, input int b, input int op);
    int r;
    case (op)
      0: r = a + b;
      1: r = ((a - b) & 255) | ((a >= b) ? 256 : 0);
      2: r = a | b;
      default: r = a & b;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input int exp);
    int act;
    act = {23'd0, c_mon, z_mon};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h op=%0d actual=%03h expected=%03h",
               tag, a_drv, b_drv, op_drv, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2/R3";
      2: return "R4/R6";
      default: return "R5/R6";
    endcase
  endfunction

  // drive just after posedge, compare at the following negedge
  task automatic apply(input int a, input int b, input int op, input string tag);
    @(posedge clk);
    a_drv  = 8'(a);
    b_drv  = 8'(b);
    op_drv = 2'(op);
    @(negedge clk);
    check(tag, model(a, b, op));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc <= n_cyc + 1;
    if (n_cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", n_cyc, WATCHDOG);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: zero operands, sum
    @(negedge clk);
    check("R1 initial", 0);

    // R7 all-ones corner, each op
    apply(255, 255, 0, "R7 add");
    check("R7 add const", 9'h1FE);
    apply(255, 255, 1, "R7 sub");
    check("R7 sub const", 9'h100);
    apply(255, 255, 2, "R7 or");
    check("R7 or const", 9'h0FF);
    apply(255, 255, 3, "R7 and");
    check("R7 and const", 9'h0FF);
    // R7 first carry: 0-0 must not borrow
    apply(0, 0, 1, "R7 cin");
    check("R7 cin const", 9'h100);

    // R8 full ripple
    apply(255, 1, 0, "R8 ripple");
    check("R8 ripple const", 9'h100);
    apply(0, 1, 1, "R8 borrow");
    check("R8 borrow const", 9'h0FF);
    apply(128, 128, 0, "R8 top");
    check("R8 top const", 9'h100);

    // R9: change inputs mid-cycle, no clock edge between
    @(negedge clk);
    a_drv = 8'h3C; b_drv = 8'h0F; op_drv = 2'b00;
    #1 check("R9 comb", model(8'h3C, 8'h0F, 0));
    op_drv = 2'b01;
    #1 check("R9 comb", model(8'h3C, 8'h0F, 1));
    a_drv = 8'h05; op_drv = 2'b11;
    #1 check("R9 comb", model(8'h05, 8'h0F, 3));
    a_drv = 8'h0F;
    #1 check("R9 comb", model(8'h0F, 8'h0F, 3));

    // R3 equal operands, boundary
    apply(77, 77, 1, "R3 equal");
    apply(76, 77, 1, "R3 below");
    apply(78, 77, 1, "R3 above");
    // R6 logic ops with large operands
    apply(200, 200, 2, "R6 or");
    apply(200, 200, 3, "R6 and");

    // exhaustive sum and difference
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(a, b, op, tag_of(op));

    // dense grid for OR and AND
    for (int op = 2; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 4)
          apply(a, b ^ (a & 3), op, tag_of(op));

    done = 1'b1;
    summary();
  end

endmodule